// File: doc/BRIEF.md
# Delayed-Branch Front-End Control with Not-Taken Fetch

This block steers the fetch address and the early pipeline valid bits of an eight-stage in-order pipeline. Branch conditions and targets are only known when the branch occupies the execute stage. By then three younger instructions have already been fetched. The first of these is the architectural delay slot. The next two were fetched on the assumption that the branch falls through. If the branch is not taken, all three simply continue. If it is taken, the two younger instructions are squashed into bubbles and fetch restarts at the target. A "likely" branch variant instead cancels its delay-slot instruction when it resolves not taken.

Decode presents the branch and likely flags for the instruction in the register-fetch stage. Execute presents the condition result and the target for the instruction in the execute stage. A load-interlock hold freezes the fetch, second-fetch and register-fetch stages and sends a bubble into execute. A small controller sequences every branch through four named states:

- **RUN**: streaming with no branch in execute.
- **STALL**: the interlock is holding the front end.
- **RESOLVE**: a live branch is in execute this cycle.
- **REFILL**: the cycle after a redirect.

The transitions are:

- RUN, STALL and REFILL go to RESOLVE when a live branch leaves register fetch.
- Otherwise they go to STALL while the hold is asserted, and to RUN when it is not.
- RESOLVE goes to REFILL when the branch is taken.
- RESOLVE goes to STALL or RUN, according to the hold, when the branch is not taken.

Top module: `brctl_top`

## Requirements
- R1: While reset is asserted, the fetch address equals the RESET_PC parameter, the register-fetch and execute valid bits are 0, and no redirect or kill is asserted.
- R2: With no hold and no redirect, the fetch address advances by STEP bytes (default 4) every cycle, and instructions enter execute in fetch order.
- R3: A branch is acted on only in the cycle it is valid in execute, one cycle after it leaves register fetch. Its condition and target inputs are ignored in every other cycle.
- R4: For an ordinary branch, the instruction fetched right after it (the delay slot) reaches execute as valid, whether the branch is taken or not.
- R5: For a branch that is not taken, the two instructions after the delay slot continue and reach execute in sequence.
- R6: For a taken branch, in its resolve cycle redirect_o, kill_is_o and kill_if_o are 1 and kill_rf_o is 0. The next fetch address equals the target. Exactly two bubbles then reach execute between the delay slot and the target.
- R7: For a likely branch that is not taken, kill_rf_o is 1 in the resolve cycle and the delay slot never reaches execute as valid. The following sequential instructions continue.
- R8: For a likely branch that is taken, the delay slot executes and the two following instructions are squashed, as in R6.
- R9: While hold_i is 1 and no redirect occurs, the fetch address and the register-fetch instruction stay unchanged, and execute receives a bubble.
- R10: A redirect and squash in the same cycle as hold_i take priority. The fetch address loads the target, the squashed stages become bubbles, and the held delay slot still executes afterwards.
- R11: A branch flag on an instruction that was squashed is ignored and causes no redirect.
- R12: A branch flag on the delay-slot instruction of a live branch is ignored and causes no redirect.
- R13: pc_sel_o encodes 0 for sequential, 1 for hold and 2 for target. Target overrides hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_i | input | 1 | Load-interlock hold of the fetch, second-fetch and register-fetch stages |
| rf_branch_i | input | 1 | Decode flag: the register-fetch instruction is a branch |
| rf_likely_i | input | 1 | Decode flag: the branch is the likely variant |
| ex_taken_i | input | 1 | Condition result for the instruction in execute |
| ex_target_i | input | PC_W | Target for the instruction in execute |
| fetch_pc_o | output | PC_W | Address being fetched this cycle |
| pc_sel_o | output | 2 | Next-address select (0 sequential, 1 hold, 2 target) |
| redirect_o | output | 1 | One-cycle strobe for a taken-branch redirect |
| kill_if_o | output | 1 | Squash the first fetch-stage instruction |
| kill_is_o | output | 1 | Squash the second fetch-stage instruction |
| kill_rf_o | output | 1 | Cancel the register-fetch instruction (likely, not taken) |
| rf_valid_o | output | 1 | Register-fetch stage holds a live instruction |
| rf_pc_o | output | PC_W | Address of the register-fetch instruction |
| ex_valid_o | output | 1 | Execute stage holds a live instruction |
| ex_pc_o | output | PC_W | Address of the execute instruction |

## Verification
The bench compares the full per-cycle execute stream, bubbles included, against the expected stream for each scenario. It runs ordinary and likely branches in both directions.

- A design that squashed the delay slot of a taken branch, or cancelled it for a likely branch that is taken, would drop one address from the stream.
- A design that inserted one or three bubbles would shift the target by a cycle.

Decoy branch flags are placed on a squashed slot and on a delay slot, with the condition input forced to taken. A design that trusted raw decode flags would redirect to a wrong address.

A hold is raised exactly in the resolve cycle. A design that let the interlock win would keep fetching sequentially or lose the held delay slot.

// File: rtl/brctl_pkg.sv
package brctl_pkg;

    typedef enum logic [1:0] {
        PCS_SEQ    = 2'd0,
        PCS_HOLD   = 2'd1,
        PCS_TARGET = 2'd2
    } pc_sel_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STALL   = 2'd1,
        ST_RESOLVE = 2'd2,
        ST_REFILL  = 2'd3
    } br_state_e;

endpackage

// File: rtl/brctl_stage.sv
module brctl_stage #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_i,
    input  logic            kill_i,
    input  logic            d_valid_i,
    input  logic [PC_W-1:0] d_pc_i,
    output logic            q_valid_o,
    output logic [PC_W-1:0] q_pc_o
);

    logic            valid_q;
    logic [PC_W-1:0] pc_q;

    // A held stage keeps its address; a kill turns it into a bubble in place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pc_q    <= '0;
        end else if (hold_i) begin
            valid_q <= valid_q && !kill_i;
        end else begin
            valid_q <= d_valid_i;
            pc_q    <= d_pc_i;
        end
    end

    assign q_valid_o = valid_q;
    assign q_pc_o    = pc_q;

endmodule

// File: rtl/brctl_pcgen.sv
module brctl_pcgen
    import brctl_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter int              STEP     = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pc_sel_e         pc_sel_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] pc_o
);

    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;

    always_comb begin
        case (pc_sel_i)
            PCS_SEQ:    pc_d = pc_q + STEP_V;
            PCS_HOLD:   pc_d = pc_q;
            PCS_TARGET: pc_d = target_i;
            default:    pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/brctl_fsm.sv
module brctl_fsm
    import brctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold_i,
    input  logic    rf_valid_i,
    input  logic    rf_branch_i,
    input  logic    rf_likely_i,
    input  logic    ex_taken_i,
    output pc_sel_e pc_sel_o,
    output logic    redirect_o,
    output logic    kill_if_o,
    output logic    kill_is_o,
    output logic    kill_rf_o
);

    br_state_e state_q, state_d;
    logic      likely_q;
    logic      dslot_q;
    logic      live_br;
    logic      br_adv;

    // A branch flag counts only on a live instruction that is not a delay slot.
    assign live_br = rf_valid_i && rf_branch_i && !dslot_q;
    assign br_adv  = live_br && !hold_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            likely_q <= 1'b0;
            dslot_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (br_adv) likely_q <= rf_likely_i;
            // When a branch advances, the instruction moving into RF is its delay slot.
            if (!hold_i) dslot_q <= br_adv;
        end
    end

    always_comb begin
        state_d    = state_q;
        pc_sel_o   = hold_i ? PCS_HOLD : PCS_SEQ;
        redirect_o = 1'b0;
        kill_if_o  = 1'b0;
        kill_is_o  = 1'b0;
        kill_rf_o  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (br_adv)      state_d = ST_RESOLVE;
                else if (hold_i) state_d = ST_STALL;
                else             state_d = ST_RUN;
            end
            ST_STALL: begin
                if (br_adv)      state_d = ST_RESOLVE;
                else if (hold_i) state_d = ST_STALL;
                else             state_d = ST_RUN;
            end
            ST_RESOLVE: begin
                if (ex_taken_i) begin
                    pc_sel_o   = PCS_TARGET;
                    redirect_o = 1'b1;
                    kill_if_o  = 1'b1;
                    kill_is_o  = 1'b1;
                    state_d    = ST_REFILL;
                end else begin
                    kill_rf_o  = likely_q;
                    state_d    = hold_i ? ST_STALL : ST_RUN;
                end
            end
            ST_REFILL: begin
                if (br_adv)      state_d = ST_RESOLVE;
                else if (hold_i) state_d = ST_STALL;
                else             state_d = ST_RUN;
            end
        endcase
    end

    // R6: a redirect is a single-cycle strobe
    p_redirect_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    // R6: a redirect squashes both predicted slots and never the delay slot
    p_squash_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (kill_if_o && kill_is_o && !kill_rf_o));

    // R3: a branch leaving RF is resolved in the very next cycle
    p_resolve_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        br_adv |=> (state_q == ST_RESOLVE));

    // R12: during resolve the RF instruction is the delay slot and never counts as a branch
    p_dslot_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESOLVE) |-> !live_br);

    // R7: cancelling the delay slot and redirecting never happen together
    p_cancel_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        kill_rf_o |-> (!redirect_o && !kill_is_o));

endmodule

// File: rtl/brctl_top.sv
module brctl_top
    import brctl_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter int              STEP     = 4,
    parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_i,
    input  logic            rf_branch_i,
    input  logic            rf_likely_i,
    input  logic            ex_taken_i,
    input  logic [PC_W-1:0] ex_target_i,
    output logic [PC_W-1:0] fetch_pc_o,
    output logic [1:0]      pc_sel_o,
    output logic            redirect_o,
    output logic            kill_if_o,
    output logic            kill_is_o,
    output logic            kill_rf_o,
    output logic            rf_valid_o,
    output logic [PC_W-1:0] rf_pc_o,
    output logic            ex_valid_o,
    output logic [PC_W-1:0] ex_pc_o
);

    // The held front-end stages behind IF are second fetch (index 0) and register fetch (index 1).
    localparam int              NUM_HELD = 2;
    localparam logic [PC_W-1:0] STEP_V   = PC_W'(STEP);

    pc_sel_e         pc_sel;
    logic [PC_W-1:0] fetch_pc;
    logic            k_if, k_is, k_rf, redir;

    logic [NUM_HELD-1:0] st_valid;
    logic [PC_W-1:0]     st_pc   [NUM_HELD];
    logic [NUM_HELD-1:0] st_kill;

    assign st_kill = {k_rf, k_is};

    brctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (hold_i),
        .rf_valid_i  (st_valid[NUM_HELD-1]),
        .rf_branch_i (rf_branch_i),
        .rf_likely_i (rf_likely_i),
        .ex_taken_i  (ex_taken_i),
        .pc_sel_o    (pc_sel),
        .redirect_o  (redir),
        .kill_if_o   (k_if),
        .kill_is_o   (k_is),
        .kill_rf_o   (k_rf)
    );

    brctl_pcgen #(
        .PC_W     (PC_W),
        .STEP     (STEP),
        .RESET_PC (RESET_PC)
    ) u_pcgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_sel_i (pc_sel),
        .target_i (ex_target_i),
        .pc_o     (fetch_pc)
    );

    for (genvar i = 0; i < NUM_HELD; i++) begin : g_held
        logic            d_valid;
        logic [PC_W-1:0] d_pc;
        if (i == 0) begin : g_first
            assign d_valid = !k_if;
            assign d_pc    = fetch_pc;
        end else begin : g_next
            assign d_valid = st_valid[i-1] && !st_kill[i-1];
            assign d_pc    = st_pc[i-1];
        end
        brctl_stage #(.PC_W(PC_W)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold_i    (hold_i),
            .kill_i    (st_kill[i]),
            .d_valid_i (d_valid),
            .d_pc_i    (d_pc),
            .q_valid_o (st_valid[i]),
            .q_pc_o    (st_pc[i])
        );
    end

    // Execute is never held; the interlock or a cancelled delay slot sends it a bubble.
    logic ex_d_valid;
    assign ex_d_valid = st_valid[NUM_HELD-1] && !k_rf && !hold_i;

    brctl_stage #(.PC_W(PC_W)) u_ex (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (1'b0),
        .kill_i    (1'b0),
        .d_valid_i (ex_d_valid),
        .d_pc_i    (st_pc[NUM_HELD-1]),
        .q_valid_o (ex_valid_o),
        .q_pc_o    (ex_pc_o)
    );

    assign fetch_pc_o = fetch_pc;
    assign pc_sel_o   = pc_sel;
    assign redirect_o = redir;
    assign kill_if_o  = k_if;
    assign kill_is_o  = k_is;
    assign kill_rf_o  = k_rf;
    assign rf_valid_o = st_valid[NUM_HELD-1];
    assign rf_pc_o    = st_pc[NUM_HELD-1];

    // R2: a free-running front end steps the fetch address
    p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !redirect_o) |=> (fetch_pc_o == $past(fetch_pc_o) + STEP_V));

    // R6: the cycle after a redirect fetches the target
    p_fetch_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> (fetch_pc_o == $past(ex_target_i)));

    // R9: the interlock freezes the fetch address and the RF instruction
    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !redirect_o) |=> ($stable(fetch_pc_o) && $stable(rf_pc_o)));

    // R9: the interlock sends a bubble into execute
    p_hold_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !ex_valid_o);

    // R6: without a hold, the squashed slot lands in RF as a bubble
    p_squash_rf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && !hold_i) |=> !rf_valid_o);

    // R7: a cancelled delay slot never reaches execute
    p_cancel_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        kill_rf_o |=> !ex_valid_o);

endmodule

// File: tb/tb_brctl_top.sv
module tb_brctl_top;

    localparam logic [31:0] RST_PC = 32'h0000_1000;
    localparam logic [31:0] NONE   = 32'hFFFF_FFF0;
    localparam logic [31:0] DECOY_TGT = 32'h0000_3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_i = 1'b0;
    logic        rf_branch_i = 1'b0;
    logic        rf_likely_i = 1'b0;
    logic        ex_taken_i = 1'b0;
    logic [31:0] ex_target_i = '0;
    logic [31:0] fetch_pc_o, rf_pc_o, ex_pc_o;
    logic [1:0]  pc_sel_o;
    logic        redirect_o, kill_if_o, kill_is_o, kill_rf_o, rf_valid_o, ex_valid_o;

    brctl_top #(.PC_W(32), .STEP(4), .RESET_PC(RST_PC)) dut (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i),
        .rf_branch_i(rf_branch_i), .rf_likely_i(rf_likely_i),
        .ex_taken_i(ex_taken_i), .ex_target_i(ex_target_i),
        .fetch_pc_o(fetch_pc_o), .pc_sel_o(pc_sel_o), .redirect_o(redirect_o),
        .kill_if_o(kill_if_o), .kill_is_o(kill_is_o), .kill_rf_o(kill_rf_o),
        .rf_valid_o(rf_valid_o), .rf_pc_o(rf_pc_o),
        .ex_valid_o(ex_valid_o), .ex_pc_o(ex_pc_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_chk = 0;
    int n_fail = 0;

    // Scenario program
    logic [31:0] br_pc = NONE, br_tgt = '0, dec_pc = NONE, hold_pc = NONE;
    bit          br_lk = 0, br_tk = 0, hold_done = 0;
    int          hold_len = 0, hold_left = 0;
    string       cur_req = "R2";

    logic [32:0] exp_q [$];
    bit          started = 0;
    bit          prev_hold = 0, prev_redir = 0;
    logic [31:0] prev_fetch = '0, prev_tgt = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic exp_pc(input logic [31:0] pc);
        exp_q.push_back({1'b1, pc});
    endtask

    task automatic exp_bub();
        exp_q.push_back(33'd0);
    endtask

    // Driver and monitor: inputs at the falling edge, checks 1 ns later.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                hold_i = 0; hold_left = 0; started = 0;
                prev_hold = 0; prev_redir = 0;
            end else begin
                if (hold_left > 0) begin
                    hold_i = 1; hold_left--;
                end else if (ex_valid_o && ex_pc_o == hold_pc && !hold_done) begin
                    hold_i = 1; hold_done = 1; hold_left = hold_len - 1;
                end else begin
                    hold_i = 0;
                end
            end
            rf_branch_i = (rf_pc_o == br_pc) || (rf_pc_o == dec_pc);
            rf_likely_i = (rf_pc_o == br_pc) && br_lk;
            ex_taken_i  = (ex_pc_o == br_pc) ? br_tk : (ex_pc_o == dec_pc);
            ex_target_i = (ex_pc_o == br_pc) ? br_tgt : DECOY_TGT;
            #1;
            if (rst_n) begin
                if (prev_hold && !prev_redir)
                    check(fetch_pc_o == prev_fetch, "R9", "fetch address held", fetch_pc_o, prev_fetch);
                if (prev_redir)
                    check(fetch_pc_o == prev_tgt, "R10", "fetch address after redirect", fetch_pc_o, prev_tgt);
                if (ex_valid_o && ex_pc_o == br_pc) begin
                    check(redirect_o == br_tk, "R3", "redirect at resolve", 32'(redirect_o), 32'(br_tk));
                    check(pc_sel_o == (br_tk ? 2'd2 : (hold_i ? 2'd1 : 2'd0)), "R13", "pc select at resolve",
                          32'(pc_sel_o), 32'(br_tk ? 2'd2 : (hold_i ? 2'd1 : 2'd0)));
                    check(kill_is_o == br_tk && kill_if_o == br_tk, "R6", "squash of predicted slots",
                          32'({kill_is_o, kill_if_o}), 32'({br_tk, br_tk}));
                    check(kill_rf_o == (br_lk && !br_tk), "R7", "delay slot cancel",
                          32'(kill_rf_o), 32'(br_lk && !br_tk));
                end else begin
                    // R11 R12: decoy flags elsewhere never cause a redirect
                    check(!redirect_o, "R12", "no redirect outside a live resolve", 32'(redirect_o), 32'd0);
                end
                if (!started && ex_valid_o) started = 1;
                if (started && exp_q.size() > 0) begin
                    logic [32:0] e;
                    logic [32:0] a;
                    e = exp_q.pop_front();
                    a = ex_valid_o ? {1'b1, ex_pc_o} : 33'd0;
                    check(a == e, cur_req, "execute stream", a[31:0] | {31'd0, a[32]} << 31, e[31:0] | {31'd0, e[32]} << 31);
                end
                prev_hold  = hold_i;
                prev_redir = redirect_o;
                prev_fetch = fetch_pc_o;
                prev_tgt   = ex_target_i;
            end
        end
    end

    task automatic start_case(input string req, input logic [31:0] bp, input bit lk, input bit tk,
                              input logic [31:0] dp, input logic [31:0] hp, input int hl);
        @(negedge clk);
        rst_n = 0;
        cur_req = req; br_pc = bp; br_lk = lk; br_tk = tk; br_tgt = 32'h0000_2000;
        dec_pc = dp; hold_pc = hp; hold_len = hl; hold_done = 0;
        exp_q.delete();
    endtask

    task automatic release_and_wait();
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        check(fetch_pc_o == RST_PC, "R1", "reset fetch address", fetch_pc_o, RST_PC);
        check(!rf_valid_o && !ex_valid_o, "R1", "reset valid bits", 32'({rf_valid_o, ex_valid_o}), 32'd0);
        check(!redirect_o && !kill_rf_o && !kill_is_o && !kill_if_o, "R1", "reset strobes",
              32'({redirect_o, kill_rf_o, kill_is_o, kill_if_o}), 32'd0);
        rst_n = 1;
        for (int i = 0; i < 60 && exp_q.size() > 0; i++) @(negedge clk);
        #3;
        check(exp_q.size() == 0, cur_req, "stream complete", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic prefix();
        exp_pc(32'h1000); exp_pc(32'h1004); exp_pc(32'h1008);
    endtask

    initial begin
        // R2 R5 R4: ordinary not-taken branch at 0x1008
        start_case("R5", 32'h1008, 0, 0, NONE, NONE, 0);
        prefix(); exp_pc(32'h100C); exp_pc(32'h1010); exp_pc(32'h1014); exp_pc(32'h1018); exp_pc(32'h101C);
        release_and_wait();

        // R6 R4: ordinary taken branch: delay slot, two bubbles, target
        start_case("R6", 32'h1008, 0, 1, NONE, NONE, 0);
        prefix(); exp_pc(32'h100C); exp_bub(); exp_bub(); exp_pc(32'h2000); exp_pc(32'h2004); exp_pc(32'h2008);
        release_and_wait();

        // R7: likely, not taken: delay slot cancelled
        start_case("R7", 32'h1008, 1, 0, NONE, NONE, 0);
        prefix(); exp_bub(); exp_pc(32'h1010); exp_pc(32'h1014); exp_pc(32'h1018);
        release_and_wait();

        // R8: likely, taken: delay slot kept, two bubbles, target
        start_case("R8", 32'h1008, 1, 1, NONE, NONE, 0);
        prefix(); exp_pc(32'h100C); exp_bub(); exp_bub(); exp_pc(32'h2000); exp_pc(32'h2004);
        release_and_wait();

        // R11: taken-flagged decoy branch in a squashed slot is ignored
        start_case("R11", 32'h1008, 0, 1, 32'h1010, NONE, 0);
        prefix(); exp_pc(32'h100C); exp_bub(); exp_bub(); exp_pc(32'h2000); exp_pc(32'h2004); exp_pc(32'h2008);
        release_and_wait();

        // R12: taken-flagged decoy in the delay slot of a not-taken branch is ignored
        start_case("R12", 32'h1008, 0, 0, 32'h100C, NONE, 0);
        prefix(); exp_pc(32'h100C); exp_pc(32'h1010); exp_pc(32'h1014); exp_pc(32'h1018);
        release_and_wait();

        // R9: two-cycle interlock with no branch in flight
        start_case("R9", NONE, 0, 0, NONE, 32'h1004, 2);
        exp_pc(32'h1000); exp_pc(32'h1004); exp_bub(); exp_bub(); exp_pc(32'h1008); exp_pc(32'h100C); exp_pc(32'h1010);
        release_and_wait();

        // R10: interlock in the resolve cycle of a taken branch
        start_case("R10", 32'h1008, 0, 1, NONE, 32'h1008, 1);
        prefix(); exp_bub(); exp_pc(32'h100C); exp_bub(); exp_pc(32'h2000); exp_pc(32'h2004);
        release_and_wait();

        // R10 R7: interlock in the resolve cycle of a likely not-taken branch
        start_case("R7", 32'h1008, 1, 0, NONE, 32'h1008, 1);
        prefix(); exp_bub(); exp_bub(); exp_pc(32'h1010); exp_pc(32'h1014);
        release_and_wait();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule